// File: doc/BRIEF.md
# Transport-Triggered Move Datapath Core

This core executes programs made only of data moves. Each clock it fetches one wide instruction word from an internal program store. The word holds one slot per transport bus, and each slot names a source port, a destination port and a guard. A move that writes the trigger port of a function unit starts that unit's operation. The result can be moved on by a later instruction, either into the register file or straight into another unit's operand port.

The core has four kinds of unit on its buses: an adder, a multiplier, an eight-entry register file and an input/output unit. Every slot also carries an immediate field that can be used as a source. The program store is filled through a write port while reset is held. Execution begins at address 0 when reset is released. It continues one instruction per cycle until a move reaches the halt destination.

Top module: `tta_core`

## Requirements
- R1: While `rst` is high, `ioOutValid`, `halted` and `ioInRead` are 0. After `rst` falls, the first instruction executed is the one at address 0.
- R2: An instruction is NUM_BUS slots of 42 bits, with bus b in bits [42b+41:42b]. Within a slot, the guard is bits [41:39], the source is [38:32], the destination is [31:25] and the immediate is [24:0].
- R3: Source codes: 0x00 gives the low DATA_W bits of the slot's immediate (upper bits ignored), 0x01 the adder result, 0x02 the multiplier result, 0x03 the external input and 0x10+n register n. Destination codes: 0x01/0x02 are the adder operand and trigger, 0x03/0x04 the multiplier operand and trigger, 0x05 the output, 0x06 halt, 0x08+g guard flag g (0..2) and 0x10+n register n.
- R4: A write to an operand port (0x01 or 0x03) only stores the operand. The unit's result does not change.
- R5: A write to a trigger port produces a result that a move in the next instruction can read: the sum for the adder, the low DATA_W bits of the product for the multiplier. The operand used is the stored one, or the one written to the operand port in the same instruction.
- R6: A move reading source 0x03 raises `ioInRead` during that cycle and transfers `ioInData`. Several buses reading it in one instruction get the same word. A move to 0x05 shows its data on `ioOutData` with `ioOutValid` high for the one cycle after that clock edge.
- R7: Guard bits [40:39] select 0 = always, 1..3 = guard flag 0..2, and bit 41 inverts the selection. A slot whose guard evaluates false moves nothing. A guard flag becomes 1 when it is written with a nonzero word and 0 when written with zero. All flags reset to 0.
- R8: A slot with destination 0x00 changes no state.
- R9: All buses move in the same cycle. When two buses write one destination, the higher-numbered bus wins.
- R10: Register file reads return the values from before the current instruction's writes, so two moves in one instruction swap two registers.
- R11: The program counter rises by one each cycle and wraps after the last address. A move to 0x06 sets `halted`. The other moves of that instruction complete, and no later move executes.
- R12: The program that computes a + b*b runs in four instructions. It feeds the product straight into the adder trigger, and the correct sum modulo 2^DATA_W appears on the output.
- R13: Writes through `progWe` change the program store only while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also enables program loading |
| progWe | input | 1 | Program store write strobe |
| progAddr | input | 4 | Program store write address (log2 IMEM_DEPTH) |
| progData | input | 84 | Instruction word to store (NUM_BUS*42) |
| ioInData | input | 16 | Current external input word |
| ioInRead | output | 1 | High in a cycle whose instruction consumes `ioInData` |
| ioOutData | output | 16 | Last word moved to the output port |
| ioOutValid | output | 1 | One-cycle strobe for a new `ioOutData` |
| halted | output | 1 | Fetch has stopped on a halt move |

## Verification
The a + b*b program is run over a table of operand pairs that separate the possible faults. Small values check ordinary arithmetic. Zero operands show whether the multiplier term is dropped or the sum is built from the wrong operand. Pairs whose product or sum overflows 16 bits check the truncation of both units. A second directed program mixes register swaps, conflicting bus writes, true and false guards (plain and inverted), and operand-only writes. The distinct output values it produces show which rule was broken. A third program checks that the counter wraps to address 0, and that a program write attempted while running leaves the store unchanged.

// File: rtl/tta_pkg.sv
`timescale 1ns/1ps
package tta_pkg;
  // slot layout
  localparam int SLOT_W    = 42;
  localparam int PORT_W    = 7;
  localparam int GUARD_W   = 3;
  localparam int IMM_W     = SLOT_W - GUARD_W - 2 * PORT_W;
  localparam int IMM_LSB   = 0;
  localparam int DST_LSB   = IMM_LSB + IMM_W;
  localparam int SRC_LSB   = DST_LSB + PORT_W;
  localparam int GUARD_LSB = SRC_LSB + PORT_W;
  localparam int GSEL_W    = GUARD_W - 1;
  localparam int NUM_GUARDS = (1 << GSEL_W) - 1;

  typedef logic [PORT_W-1:0] port_t;

  // destination codes
  localparam port_t DST_NONE       = 7'h00;
  localparam port_t DST_ADD_OPD    = 7'h01;
  localparam port_t DST_ADD_TRG    = 7'h02;
  localparam port_t DST_MUL_OPD    = 7'h03;
  localparam port_t DST_MUL_TRG    = 7'h04;
  localparam port_t DST_IO_OUT     = 7'h05;
  localparam port_t DST_HALT       = 7'h06;
  localparam port_t DST_GUARD_BASE = 7'h08;
  localparam port_t DST_REG_BASE   = 7'h10;

  // source codes
  localparam port_t SRC_IMM      = 7'h00;
  localparam port_t SRC_ADD_RES  = 7'h01;
  localparam port_t SRC_MUL_RES  = 7'h02;
  localparam port_t SRC_IO_IN    = 7'h03;
  localparam port_t SRC_REG_BASE = 7'h10;

  // one decoded bus transfer, control -> datapath
  typedef struct packed {
    logic             go;
    port_t            src;
    port_t            dst;
    logic [IMM_W-1:0] imm;
  } move_t;

  function automatic logic guard_pass(input logic [GUARD_W-1:0] code,
                                      input logic [NUM_GUARDS-1:0] flags);
    logic sel;
    sel = 1'b1;
    for (int g = 0; g < NUM_GUARDS; g++)
      if (code[GSEL_W-1:0] == GSEL_W'(g + 1)) sel = flags[g];
    return sel ^ code[GUARD_W-1];
  endfunction
endpackage

// File: rtl/tta_fu.sv
`timescale 1ns/1ps
module tta_fu #(
  parameter int DATA_W  = 16,
  parameter bit USE_MUL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opdWe,
  input  logic [DATA_W-1:0] opdData,
  input  logic              trgWe,
  input  logic [DATA_W-1:0] trgData,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] opdReg;
  logic [DATA_W-1:0] opdEff;
  logic [DATA_W-1:0] computed;

  // same-instruction operand write is forwarded to the trigger
  assign opdEff = opdWe ? opdData : opdReg;

  generate
    if (USE_MUL) begin : g_mul
      assign computed = DATA_W'(opdEff * trgData);
    end else begin : g_add
      assign computed = opdEff + trgData;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      opdReg <= '0;
      result <= '0;
    end else begin
      if (opdWe) opdReg <= opdData;
      if (trgWe) result <= computed;
    end
  end
endmodule

// File: rtl/tta_control.sv
`timescale 1ns/1ps
module tta_control
  import tta_pkg::*;
#(
  parameter int NUM_BUS    = 2,
  parameter int IMEM_DEPTH = 16,
  localparam int INSTR_W   = NUM_BUS * SLOT_W,
  localparam int PC_W      = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  progWe,
  input  logic [PC_W-1:0]       progAddr,
  input  logic [INSTR_W-1:0]    progData,
  input  logic [NUM_GUARDS-1:0] guardFlags,
  output move_t [NUM_BUS-1:0]   moves,
  output logic                  halted,
  output logic [PC_W-1:0]       pc
);
  logic [INSTR_W-1:0] imem [IMEM_DEPTH];
  logic [INSTR_W-1:0] fetchWord;
  logic [SLOT_W-1:0]  slot;
  logic [PC_W-1:0]    pcNext;
  logic               haltHit;

  always_ff @(posedge clk) begin
    if (rst && progWe) imem[progAddr] <= progData;
  end

  assign fetchWord = imem[pc];
  assign pcNext    = (pc == PC_W'(IMEM_DEPTH - 1)) ? '0 : pc + 1'b1;

  always_comb begin
    haltHit = 1'b0;
    slot    = '0;
    for (int b = 0; b < NUM_BUS; b++) begin
      slot         = fetchWord[b*SLOT_W +: SLOT_W];
      moves[b].src = slot[SRC_LSB +: PORT_W];
      moves[b].dst = slot[DST_LSB +: PORT_W];
      moves[b].imm = slot[IMM_LSB +: IMM_W];
      moves[b].go  = !rst && !halted &&
                     guard_pass(slot[GUARD_LSB +: GUARD_W], guardFlags);
      if (moves[b].go && moves[b].dst == DST_HALT) haltHit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (haltHit) halted <= 1'b1;
      else         pc     <= pcNext;
    end
  end
endmodule

// File: rtl/tta_datapath.sv
`timescale 1ns/1ps
module tta_datapath
  import tta_pkg::*;
#(
  parameter int NUM_BUS  = 2,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  move_t [NUM_BUS-1:0]   moves,
  input  logic [DATA_W-1:0]     ioInData,
  output logic                  ioInRead,
  output logic [DATA_W-1:0]     ioOutData,
  output logic                  ioOutValid,
  output logic [NUM_GUARDS-1:0] guardFlags
);
  logic [DATA_W-1:0] addRes, mulRes;
  logic [DATA_W-1:0] rf [NUM_REGS];
  logic [DATA_W-1:0] busData [NUM_BUS];

  logic              addOpWe, addTrWe, mulOpWe, mulTrWe, outWe;
  logic [DATA_W-1:0] addOpWd, addTrWd, mulOpWd, mulTrWd, outWd;
  logic [NUM_GUARDS-1:0] gWe, gWd;
  logic [NUM_REGS-1:0]   rWe;
  logic [DATA_W-1:0]     rWd [NUM_REGS];

  // source side: every bus reads pre-edge state
  always_comb begin
    ioInRead = 1'b0;
    for (int b = 0; b < NUM_BUS; b++) begin
      busData[b] = '0;
      case (moves[b].src)
        SRC_IMM:     busData[b] = DATA_W'(moves[b].imm);
        SRC_ADD_RES: busData[b] = addRes;
        SRC_MUL_RES: busData[b] = mulRes;
        SRC_IO_IN:   busData[b] = ioInData;
        default: begin
          for (int r = 0; r < NUM_REGS; r++)
            if (moves[b].src == port_t'(SRC_REG_BASE + r)) busData[b] = rf[r];
        end
      endcase
      if (moves[b].go && moves[b].src == SRC_IO_IN) ioInRead = 1'b1;
    end
  end

  // destination side: later (higher) bus overrides earlier
  always_comb begin
    addOpWe = 1'b0; addTrWe = 1'b0; mulOpWe = 1'b0; mulTrWe = 1'b0; outWe = 1'b0;
    addOpWd = '0;   addTrWd = '0;   mulOpWd = '0;   mulTrWd = '0;   outWd = '0;
    gWe = '0;
    gWd = '0;
    rWe = '0;
    for (int r = 0; r < NUM_REGS; r++) rWd[r] = '0;
    for (int b = 0; b < NUM_BUS; b++) begin
      if (moves[b].go) begin
        case (moves[b].dst)
          DST_ADD_OPD: begin addOpWe = 1'b1; addOpWd = busData[b]; end
          DST_ADD_TRG: begin addTrWe = 1'b1; addTrWd = busData[b]; end
          DST_MUL_OPD: begin mulOpWe = 1'b1; mulOpWd = busData[b]; end
          DST_MUL_TRG: begin mulTrWe = 1'b1; mulTrWd = busData[b]; end
          DST_IO_OUT:  begin outWe   = 1'b1; outWd   = busData[b]; end
          default: begin
            for (int g = 0; g < NUM_GUARDS; g++)
              if (moves[b].dst == port_t'(DST_GUARD_BASE + g)) begin
                gWe[g] = 1'b1;
                gWd[g] = |busData[b];
              end
            for (int r = 0; r < NUM_REGS; r++)
              if (moves[b].dst == port_t'(DST_REG_BASE + r)) begin
                rWe[r] = 1'b1;
                rWd[r] = busData[b];
              end
          end
        endcase
      end
    end
  end

  tta_fu #(.DATA_W(DATA_W), .USE_MUL(1'b0)) u_add (
    .clk(clk), .rst(rst),
    .opdWe(addOpWe), .opdData(addOpWd),
    .trgWe(addTrWe), .trgData(addTrWd),
    .result(addRes)
  );

  tta_fu #(.DATA_W(DATA_W), .USE_MUL(1'b1)) u_mul (
    .clk(clk), .rst(rst),
    .opdWe(mulOpWe), .opdData(mulOpWd),
    .trgWe(mulTrWe), .trgData(mulTrWd),
    .result(mulRes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) rf[r] <= '0;
      guardFlags <= '0;
      ioOutData  <= '0;
      ioOutValid <= 1'b0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++)
        if (rWe[r]) rf[r] <= rWd[r];
      for (int g = 0; g < NUM_GUARDS; g++)
        if (gWe[g]) guardFlags[g] <= gWd[g];
      ioOutValid <= outWe;
      if (outWe) ioOutData <= outWd;
    end
  end
endmodule

// File: rtl/tta_core.sv
`timescale 1ns/1ps
module tta_core
  import tta_pkg::*;
#(
  parameter int NUM_BUS    = 2,
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 8,
  parameter int IMEM_DEPTH = 16,
  localparam int INSTR_W   = NUM_BUS * SLOT_W,
  localparam int PC_W      = (IMEM_DEPTH > 1) ? $clog2(IMEM_DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               progWe,
  input  logic [PC_W-1:0]    progAddr,
  input  logic [INSTR_W-1:0] progData,
  input  logic [DATA_W-1:0]  ioInData,
  output logic               ioInRead,
  output logic [DATA_W-1:0]  ioOutData,
  output logic               ioOutValid,
  output logic               halted
);
  move_t [NUM_BUS-1:0]   moves;
  logic [NUM_GUARDS-1:0] guardFlags;
  logic [PC_W-1:0]       pcWire;

  tta_control #(.NUM_BUS(NUM_BUS), .IMEM_DEPTH(IMEM_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .progWe(progWe), .progAddr(progAddr), .progData(progData),
    .guardFlags(guardFlags),
    .moves(moves), .halted(halted), .pc(pcWire)
  );

  tta_datapath #(.NUM_BUS(NUM_BUS), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rst(rst),
    .moves(moves), .ioInData(ioInData),
    .ioInRead(ioInRead), .ioOutData(ioOutData), .ioOutValid(ioOutValid),
    .guardFlags(guardFlags)
  );
endmodule

// File: rtl/tta_core_checker.sv
`timescale 1ns/1ps
module tta_core_checker
  import tta_pkg::*;
#(
  parameter int NUM_BUS    = 2,
  parameter int IMEM_DEPTH = 16,
  parameter int PC_W       = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                halted,
  input logic [PC_W-1:0]     pc,
  input logic                ioInRead,
  input logic                ioOutValid,
  input move_t [NUM_BUS-1:0] moves
);
  logic outReq;
  always_comb begin
    outReq = 1'b0;
    for (int b = 0; b < NUM_BUS; b++)
      if (moves[b].go && moves[b].dst == DST_IO_OUT) outReq = 1'b1;
  end

  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_freezes_pc_R11: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));

  assert_pc_steps_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(halted) && !halted) |->
      pc == (($past(pc) == PC_W'(IMEM_DEPTH - 1)) ? '0 : $past(pc) + 1'b1));

  assert_halted_no_input_R11: assert property (@(posedge clk) disable iff (rst)
    halted |-> !ioInRead);

  assert_out_follows_move_R6: assert property (@(posedge clk) disable iff (rst)
    outReq |=> ioOutValid);

  assert_out_needs_move_R6: assert property (@(posedge clk) disable iff (rst)
    ioOutValid |-> $past(outReq));
endmodule

bind tta_core tta_core_checker #(
  .NUM_BUS(NUM_BUS), .IMEM_DEPTH(IMEM_DEPTH), .PC_W(PC_W)
) chk (
  .clk(clk), .rst(rst), .halted(halted), .pc(pcWire),
  .ioInRead(ioInRead), .ioOutValid(ioOutValid), .moves(moves)
);

// File: tb/tta_core_test.sv
`timescale 1ns/1ps
module tta_core_test;
  localparam int NB = 2, DW = 16, NR = 8, DEPTH = 16, SW = 42, IW = NB * SW, AW = 4;
  // port codes taken from R3
  localparam logic [6:0] D_NOP = 7'h00, D_AOP = 7'h01, D_ATR = 7'h02, D_MOP = 7'h03,
                         D_MTR = 7'h04, D_OUT = 7'h05, D_HALT = 7'h06, D_G0 = 7'h08,
                         D_R0 = 7'h10;
  localparam logic [6:0] S_IMM = 7'h00, S_ADD = 7'h01, S_MUL = 7'h02, S_IN = 7'h03,
                         S_R0 = 7'h10;
  // {a, b, a + b*b mod 2^16}
  localparam logic [47:0] VEC [6] = '{
    {16'd3,     16'd4,   16'd19},
    {16'd0,     16'd0,   16'd0},
    {16'd65535, 16'd2,   16'd3},
    {16'd255,   16'd256, 16'd255},
    {16'd7,     16'd0,   16'd7},
    {16'd1000,  16'd300, 16'd25464}
  };
  // directed program: expected outputs and the cycle each shows up
  localparam int P2_N = 8;
  localparam int P2_VAL [P2_N] = '{9, 5, 22, 0, 7, 7, 51, 600};
  localparam int P2_CYC [P2_N] = '{3, 4, 5, 7, 9, 10, 11, 12};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic progWe = 1'b0;
  logic [AW-1:0] progAddr = '0;
  logic [IW-1:0] progData = '0;
  logic [DW-1:0] ioInData = '0;
  logic ioInRead, ioOutValid, halted;
  logic [DW-1:0] ioOutData;

  always #10 clk = ~clk;

  tta_core #(.NUM_BUS(NB), .DATA_W(DW), .NUM_REGS(NR), .IMEM_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .progWe(progWe), .progAddr(progAddr), .progData(progData),
    .ioInData(ioInData), .ioInRead(ioInRead), .ioOutData(ioOutData),
    .ioOutValid(ioOutValid), .halted(halted)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [IW-1:0] prog [DEPTH];
  logic [DW-1:0] inWords [8];
  logic [DW-1:0] outVal [64];
  int outCyc [64];
  int outCount, popCount, haltCyc;

  function automatic logic [SW-1:0] mv(input logic [2:0] g, input logic [6:0] s,
                                       input logic [6:0] d, input logic [24:0] imm);
    return {g, s, d, imm};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < DEPTH; i++) prog[i] = '0;
  endtask

  task automatic loadAndReset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      progWe = 1'b1; progAddr = AW'(i); progData = prog[i];
      @(negedge clk);
    end
    progWe = 1'b0;
    check("R1", "ioOutValid in reset", 32'(ioOutValid), 0);
    check("R1", "halted in reset", 32'(halted), 0);
    check("R1", "ioInRead in reset", 32'(ioInRead), 0);
    rst = 1'b0;
  endtask

  task automatic run(input int n, input bit poke);
    int idx;
    idx = 0; outCount = 0; popCount = 0; haltCyc = -1;
    for (int c = 1; c <= n; c++) begin
      #1;
      ioInData = inWords[idx];
      if (ioInRead) begin
        popCount++;
        if (idx < 7) idx++;
      end
      if (poke && c == 1) begin
        progWe = 1'b1; progAddr = AW'(1);
        progData = {mv(3'd0, S_IMM, D_NOP, 25'd0), mv(3'd0, S_IMM, D_OUT, 25'hBAD)};
      end
      @(negedge clk);
      progWe = 1'b0;
      if (ioOutValid && outCount < 64) begin
        outVal[outCount] = ioOutData; outCyc[outCount] = c; outCount++;
      end
      if (halted && haltCyc < 0) haltCyc = c;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // ---- a + b*b program, forwarding product to adder trigger (R12)
    clearProg();
    prog[0] = {mv(3'd0, S_IMM, D_NOP, 25'd0), mv(3'd0, S_IN, D_R0, 25'd0)};
    prog[1] = {mv(3'd0, S_IN, D_MTR, 25'd0),  mv(3'd0, S_IN, D_MOP, 25'd0)};
    prog[2] = {mv(3'd0, S_R0, D_AOP, 25'd0),  mv(3'd0, S_MUL, D_ATR, 25'd0)};
    prog[3] = {mv(3'd0, S_IMM, D_HALT, 25'd0), mv(3'd0, S_ADD, D_OUT, 25'd0)};
    for (int v = 0; v < 6; v++) begin
      for (int k = 0; k < 8; k++) inWords[k] = 16'hFFFF;
      inWords[0] = VEC[v][47:32];
      inWords[1] = VEC[v][31:16];
      loadAndReset();
      run(8, 1'b0);
      check("R12", "output count", 32'(outCount), 1);
      check("R12", "a+b*b", 32'(outVal[0]), 32'(VEC[v][15:0]));
      check("R5", "result latency cycle", 32'(outCyc[0]), 4);
      check("R6", "input reads", 32'(popCount), 2);
      check("R11", "halt cycle", 32'(haltCyc), 4);
    end

    // ---- directed: swap, nop, priority, guards, operand-only writes
    clearProg();
    prog[0]  = {mv(3'd0, S_IMM, D_R0 + 7'd2, 25'd9), mv(3'd0, S_IMM, D_R0 + 7'd1, 25'd5)};
    prog[1]  = {mv(3'd0, S_R0 + 7'd2, D_R0 + 7'd1, 25'd0), mv(3'd0, S_R0 + 7'd1, D_R0 + 7'd2, 25'd0)};
    prog[2]  = {mv(3'd0, S_IMM, D_NOP, 25'd77), mv(3'd0, S_R0 + 7'd1, D_OUT, 25'd0)};
    prog[3]  = {mv(3'd0, S_IMM, D_G0, 25'd1), mv(3'd0, S_R0 + 7'd2, D_OUT, 25'd0)};
    prog[4]  = {mv(3'd0, S_IMM, D_OUT, 25'h1_0016), mv(3'd0, S_IMM, D_OUT, 25'd11)};
    prog[5]  = {mv(3'b101, S_IMM, D_R0 + 7'd3, 25'd44), mv(3'b010, S_IMM, D_OUT, 25'd33)};
    prog[6]  = {mv(3'd0, S_IMM, D_AOP, 25'd3), mv(3'b001, S_R0 + 7'd3, D_OUT, 25'd0)};
    prog[7]  = {mv(3'd0, S_IMM, D_MOP, 25'd100), mv(3'd0, S_IMM, D_ATR, 25'd4)};
    prog[8]  = {mv(3'd0, S_IMM, D_AOP, 25'd50), mv(3'd0, S_ADD, D_OUT, 25'd0)};
    prog[9]  = {mv(3'd0, S_IMM, D_ATR, 25'd1), mv(3'd0, S_ADD, D_OUT, 25'd0)};
    prog[10] = {mv(3'd0, S_IMM, D_MTR, 25'd6), mv(3'd0, S_ADD, D_OUT, 25'd0)};
    prog[11] = {mv(3'd0, S_IMM, D_HALT, 25'd0), mv(3'd0, S_MUL, D_OUT, 25'd0)};
    prog[12] = {mv(3'd0, S_IMM, D_NOP, 25'd0), mv(3'd0, S_IMM, D_OUT, 25'd99)};
    loadAndReset();
    run(16, 1'b0);
    check("R7", "outputs (guarded slots suppressed, R8 nop silent)", 32'(outCount), P2_N);
    for (int i = 0; i < P2_N; i++) begin
      string tag;
      case (i)
        0, 1:    tag = "R10";
        2:       tag = "R9";
        3:       tag = "R7";
        4, 5:    tag = "R4";
        default: tag = "R5";
      endcase
      check(tag, "directed value", 32'(outVal[i]), 32'(P2_VAL[i]));
      check(tag, "directed cycle", 32'(outCyc[i]), 32'(P2_CYC[i]));
    end
    check("R11", "halt cycle", 32'(haltCyc), 12);
    check("R11", "still halted", 32'(halted), 1);
    check("R6", "no input reads", 32'(popCount), 0);
    check("R3", "imm upper bits ignored (22)", 32'(outVal[2]), 22);

    // ---- wrap and run-time write blocked (R11, R13, R2 bus 0 low bits)
    clearProg();
    prog[0] = {mv(3'd0, S_IMM, D_NOP, 25'd0), mv(3'd0, S_IMM, D_OUT, 25'h0A0)};
    loadAndReset();
    run(20, 1'b1);
    check("R13", "outputs after blocked write", 32'(outCount), 2);
    check("R11", "first pass cycle", 32'(outCyc[0]), 1);
    check("R11", "wrap cycle", 32'(outCyc[1]), 17);
    check("R2", "bus0 slot value", 32'(outVal[1]), 32'h0A0);
    check("R11", "never halted", 32'(haltCyc), -1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule